// File: doc/BRIEF.md
# Pulse-Coded Level Link with Refresh and Watchdog

This block moves one logic level across a link that carries only short pulses. The transmit half first brings the input into the clock domain through a flop synchronizer. It then turns every rising transition into a one-cycle pulse on a "set" line and every falling transition into a one-cycle pulse on a "clear" line. While the input stays still, the transmit half sends a refresh pulse every `REFRESH_CYCLES` cycles. Each refresh pulse goes on the line that matches the present level, so a receiver that missed an edge is corrected within one refresh period.

The receive half holds a bistable output. A set pulse drives it high, a clear pulse drives it low, and it keeps its value between pulses. A watchdog counts the cycles that pass without any pulse. After `WDOG_CYCLES` such cycles it forces the output to the parameter level `DEFAULT_HIGH` and raises a timeout flag. The next pulse of either kind clears the flag and resumes normal tracking. Both halves share one clock. The link lines are brought out as ports so that the channel between them, including lost pulses, can be modelled outside the block.

Top module: `epl_link`

## Requirements
- R1: A rising transition of `din` gives exactly one `tx_set` pulse, and a falling transition gives one `tx_clr` pulse. With two synchronizer stages, the pulse is high in the third cycle after the cycle in which `din` changed.
- R2: `tx_set` and `tx_clr` are never high in the same cycle, and each pulse lasts exactly one cycle.
- R3: A cycle with `rx_set` high makes `dout` 1 in the next cycle. A cycle with only `rx_clr` high makes it 0. With no pulse and no expiry, `dout` holds. With a direct link, `dout` follows `din` four cycles after `din` changed.
- R4: While the synchronized input is steady, a refresh pulse is sent every `REFRESH_CYCLES` cycles. It goes on `tx_set` when the level is 1 and on `tx_clr` when it is 0.
- R5: Every edge pulse restarts the refresh count, so the first refresh comes exactly `REFRESH_CYCLES` cycles after the edge pulse.
- R6: An edge pulse lost on the link is corrected by the next refresh pulse, which brings `dout` to the input level.
- R7: If no pulse arrives for `WDOG_CYCLES` cycles after the cycle in which the last one was received, `timeout` goes to 1 and `dout` goes to `DEFAULT_HIGH`. Both hold while no pulse arrives. `WDOG_CYCLES` is greater than `REFRESH_CYCLES`.
- R8: The first pulse after a timeout clears `timeout` and sets `dout` from that pulse, both in the same cycle.
- R9: During and right after reset, `dout` equals `DEFAULT_HIGH`, `timeout` is 0, and both transmit lines are 0.
- R10: With the link intact and the input idle, refresh pulses keep the watchdog from expiring, so `timeout` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both halves |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 1 | Asynchronous level to be carried |
| tx_set | output | 1 | One-cycle pulse: level is, or became, 1 |
| tx_clr | output | 1 | One-cycle pulse: level is, or became, 0 |
| rx_set | input | 1 | Set pulse arriving from the link |
| rx_clr | input | 1 | Clear pulse arriving from the link |
| dout | output | 1 | Reconstructed level, or default after timeout |
| timeout | output | 1 | High while the watchdog has expired |

## Verification
The input is driven with a held level, a one-cycle glitch in each direction, a two-cycle pulse and a run that toggles every cycle. Every change is scored at its exact cycle on both the transmit line and `dout`, so a wrong latency, a merged pulse or a swapped line each stand out. Long holds at 1 and at 0 separate a refresh period that is wrong or not restarted by the edge from a refresh pulse of the wrong polarity. Cutting the link for a short time and for a long time separates repair by refresh from watchdog expiry. Reopening the link shows whether recovery and the clearing of the flag happen in one cycle.

// File: rtl/epl_pkg.sv
package epl_pkg;

  // Pulse pair carried on the link.
  typedef struct packed {
    logic set;
    logic clr;
  } epl_pulse_t;

  // Bits needed to hold values 0..lim.
  function automatic int unsigned epl_cw(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

  // True when a counter of idle cycles has reached its last value
  // before a period of 'period' cycles completes.
  function automatic logic epl_period_done(input int unsigned cnt,
                                           input int unsigned period);
    return cnt == (period - 1);
  endfunction

endpackage

// File: rtl/epl_sync.sv
module epl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/epl_tx.sv
module epl_tx
  import epl_pkg::*;
#(
  parameter int unsigned REFRESH_CYCLES = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl,
  output epl_pulse_t pulse,
  output logic       edge_evt,
  output logic       refresh_evt
);
  localparam int unsigned CW = epl_cw(REFRESH_CYCLES - 1);

  logic          lvl_d;
  logic [CW-1:0] idle_cnt;
  logic          send;

  assign edge_evt    = lvl ^ lvl_d;
  assign refresh_evt = !edge_evt && epl_period_done(32'(idle_cnt), REFRESH_CYCLES);
  assign send        = edge_evt || refresh_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_d     <= 1'b0;
      idle_cnt  <= '0;
      pulse     <= '0;
    end else begin
      lvl_d     <= lvl;
      idle_cnt  <= send ? '0 : idle_cnt + CW'(1);
      pulse.set <= send && lvl;
      pulse.clr <= send && !lvl;
    end
  end
endmodule

// File: rtl/epl_rx.sv
module epl_rx
  import epl_pkg::*;
#(
  parameter int unsigned WDOG_CYCLES  = 250,
  parameter bit          DEFAULT_HIGH = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  epl_pulse_t pulse,
  output logic       dout,
  output logic       timeout,
  output logic       hit,
  output logic       expire_evt
);
  localparam int unsigned CW = epl_cw(WDOG_CYCLES - 1);

  logic [CW-1:0] quiet_cnt;
  logic          at_limit;

  assign hit        = pulse.set || pulse.clr;
  assign at_limit   = epl_period_done(32'(quiet_cnt), WDOG_CYCLES);
  assign expire_evt = !hit && !timeout && at_limit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quiet_cnt <= '0;
      timeout   <= 1'b0;
      dout      <= DEFAULT_HIGH;
    end else begin
      if (hit)           quiet_cnt <= '0;
      else if (!at_limit) quiet_cnt <= quiet_cnt + CW'(1);

      if (hit)             timeout <= 1'b0;
      else if (expire_evt) timeout <= 1'b1;

      if (pulse.set)       dout <= 1'b1;
      else if (pulse.clr)  dout <= 1'b0;
      else if (expire_evt) dout <= DEFAULT_HIGH;
    end
  end
endmodule

// File: rtl/epl_link.sv
module epl_link
  import epl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned REFRESH_CYCLES = 50,
  parameter int unsigned WDOG_CYCLES    = 250,
  parameter bit          DEFAULT_HIGH   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic tx_set,
  output logic tx_clr,
  input  logic rx_set,
  input  logic rx_clr,
  output logic dout,
  output logic timeout
);
  // Named internal events, brought out for the checker.
  logic       sync_lvl;
  logic       tx_edge_evt;
  logic       tx_refresh_evt;
  logic       rx_hit;
  logic       rx_expire_evt;
  epl_pulse_t tx_pulse;
  epl_pulse_t rx_pulse;

  epl_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(din), .q(sync_lvl)
  );

  epl_tx #(.REFRESH_CYCLES(REFRESH_CYCLES)) tx_i (
    .clk(clk), .rst_n(rst_n), .lvl(sync_lvl), .pulse(tx_pulse),
    .edge_evt(tx_edge_evt), .refresh_evt(tx_refresh_evt)
  );

  assign tx_set       = tx_pulse.set;
  assign tx_clr       = tx_pulse.clr;
  assign rx_pulse.set = rx_set;
  assign rx_pulse.clr = rx_clr;

  epl_rx #(.WDOG_CYCLES(WDOG_CYCLES), .DEFAULT_HIGH(DEFAULT_HIGH)) rx_i (
    .clk(clk), .rst_n(rst_n), .pulse(rx_pulse), .dout(dout),
    .timeout(timeout), .hit(rx_hit), .expire_evt(rx_expire_evt)
  );
endmodule

// File: rtl/epl_link_chk.sv
module epl_link_chk #(
  parameter int unsigned REFRESH_CYCLES = 50,
  parameter int unsigned WDOG_CYCLES    = 250,
  parameter bit          DEFAULT_HIGH   = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic tx_set,
  input logic tx_clr,
  input logic rx_set,
  input logic rx_clr,
  input logic dout,
  input logic timeout,
  input logic sync_lvl,
  input logic edge_evt,
  input logic refresh_evt,
  input logic expire_evt
);
  // R7
  initial wdog_gt_refresh_chk: assert (WDOG_CYCLES > REFRESH_CYCLES);

  // R2
  tx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_set && tx_clr));
  // R2
  tx_set_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_set |=> !tx_set);
  // R2
  tx_clr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clr |=> !tx_clr);
  // R1
  rise_to_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt && sync_lvl) |=> tx_set);
  // R1
  fall_to_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt && !sync_lvl) |=> tx_clr);
  // R4
  refresh_sent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_evt |=> (tx_set || tx_clr));
  // R3
  rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_set |=> dout);
  // R3
  rx_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_clr && !rx_set) |=> !dout);
  // R3
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_set && !rx_clr && !expire_evt) |=> $stable(dout));
  // R7
  expire_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> (timeout && dout == DEFAULT_HIGH));
  // R7
  timeout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !rx_set && !rx_clr) |=> timeout);
  // R8
  recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_set || rx_clr) |=> !timeout);
endmodule

bind epl_link epl_link_chk #(
  .REFRESH_CYCLES(REFRESH_CYCLES),
  .WDOG_CYCLES(WDOG_CYCLES),
  .DEFAULT_HIGH(DEFAULT_HIGH)
) chk_i (
  .clk(clk), .rst_n(rst_n), .tx_set(tx_set), .tx_clr(tx_clr),
  .rx_set(rx_set), .rx_clr(rx_clr), .dout(dout), .timeout(timeout),
  .sync_lvl(sync_lvl), .edge_evt(tx_edge_evt),
  .refresh_evt(tx_refresh_evt), .expire_evt(rx_expire_evt)
);

// File: tb/epl_link_tb_top.sv
module epl_link_tb_top;
  localparam int R   = 20;
  localparam int W   = 80;
  localparam bit DEF = 1'b0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0;
  logic link_on = 1'b1;
  logic tx_set, tx_clr, rx_set, rx_clr, dout, timeout;

  always #10 clk = ~clk;  // 50 MHz

  assign rx_set = tx_set & link_on;
  assign rx_clr = tx_clr & link_on;

  epl_link #(.SYNC_STAGES(2), .REFRESH_CYCLES(R), .WDOG_CYCLES(W),
             .DEFAULT_HIGH(DEF)) dut_i (
    .clk(clk), .rst_n(rst_n), .din(din), .tx_set(tx_set), .tx_clr(tx_clr),
    .rx_set(rx_set), .rx_clr(rx_clr), .dout(dout), .timeout(timeout)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // Scoreboard: sig 0 = dout, 1 = tx_set, 2 = tx_clr
  typedef struct {
    int    due;
    int    sig;
    logic  val;
    string req;
  } item_t;
  item_t sbq[$];
  logic  cur = 1'b0;

  task automatic drive(input logic v);
    @(negedge clk);
    din = v;
    if (v != cur) begin
      sbq.push_back('{cyc + 3, v ? 1 : 2, 1'b1, "R1"});
      sbq.push_back('{cyc + 4, 0, v, "R3"});
    end
    cur = v;
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops scoreboard items when due
  always @(negedge clk) begin
    item_t it;
    logic  act;
    #2;
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      it  = sbq.pop_front();
      act = (it.sig == 0) ? dout : (it.sig == 1) ? tx_set : tx_clr;
      chk(it.due == cyc && act == it.val, it.req, int'(act), int'(it.val));
    end
  end

  // Last cycle a pulse was visible on the receive side
  int last_hit = 0;
  always @(negedge clk) begin
    #2;
    if (rx_set || rx_clr) last_hit = cyc;
  end

  // Sample a steady level for three refresh periods after an edge
  task automatic refresh_window(input logic v);
    int base, mism, first_ref, tmo_seen;
    drive(v);
    base = cyc; mism = 0; first_ref = -1; tmo_seen = 0;
    for (int k = 0; k < 3 * R + 5; k++) begin
      int  off;
      bit  exp_p;
      @(negedge clk); #3;
      off   = cyc - base;
      exp_p = (off >= 3) && ((off - 3) % R == 0);
      if ((v ? tx_set : tx_clr) != exp_p) mism++;
      if (v ? tx_clr : tx_set) mism++;
      if (tx_set && tx_clr) mism++;
      if (off > 3 && (tx_set || tx_clr) && first_ref < 0) first_ref = off;
      if (timeout) tmo_seen++;
    end
    chk(mism == 0, "R4", mism, 0);
    chk(first_ref == 3 + R, "R5", first_ref, 3 + R);
    chk(tmo_seen == 0, "R10", tmo_seen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    int base, t;
    // R9: reset state
    hold(3); #3;
    chk(dout == DEF, "R9", dout, DEF);
    chk(!timeout && !tx_set && !tx_clr, "R9", {timeout, tx_set, tx_clr}, 0);
    @(negedge clk); rst_n = 1'b1;
    #3;
    chk(dout == DEF && !timeout, "R9", dout, DEF);
    hold(5);

    // R1, R3: patterns scored by the monitor
    drive(1); hold(6);
    drive(0); drive(1); hold(2);   // one-cycle low glitch
    drive(0); drive(0); hold(10);
    drive(1); drive(0); drive(1); drive(0); drive(1); drive(0);
    hold(4);
    drive(1); drive(1); drive(0); hold(8);
    chk(sbq.size() == 0, "R3", sbq.size(), 0);

    // R4, R5, R10: refresh during long idle at each level
    refresh_window(1);
    refresh_window(0);
    hold(6);

    // R6: edge lost on the link, repaired by refresh
    @(negedge clk); link_on = 1'b0;
    @(negedge clk); din = 1'b1; cur = 1'b1; base = cyc;
    hold(10);
    link_on = 1'b1; #3;
    chk(dout == 1'b0, "R6", dout, 0);
    while (cyc < base + R + 3) @(negedge clk);
    #3;
    chk(dout == 1'b0, "R6", dout, 0);
    @(negedge clk); #3;
    chk(dout == 1'b1 && !timeout, "R6", dout, 1);
    hold(5);

    // R7: pulses suppressed, watchdog expiry
    @(negedge clk); link_on = 1'b0;
    t = -1;
    for (int k = 0; k < W + R + 10; k++) begin
      @(negedge clk); #3;
      if (timeout && t < 0) t = cyc;
    end
    chk(t - last_hit == W + 1, "R7", t - last_hit, W + 1);
    chk(timeout == 1'b1, "R7", timeout, 1);
    chk(dout == DEF, "R7", dout, DEF);

    // R8: recovery on first pulse after timeout
    @(negedge clk); link_on = 1'b1;
    #3;
    while (!(rx_set || rx_clr)) begin
      @(negedge clk); #3;
    end
    chk(timeout == 1'b1, "R8", timeout, 1);
    @(negedge clk); #3;
    chk(timeout == 1'b0, "R8", timeout, 0);
    chk(dout == 1'b1, "R8", dout, 1);

    // Tracking resumes after recovery
    drive(0); hold(8);
    chk(sbq.size() == 0, "R3", sbq.size(), 0);

    summary();
    $finish;
  end
endmodule